// File: doc/BRIEF.md
# Multi-channel divider-mux clock bank

This block is a bank of clock output channels sharing three input clocks. Every input clock is modelled as a single-cycle enable strobe in the system clock domain. Each channel chooses one of the three inputs and divides it by a ratio. The channel holds a separate ratio for each input, so changing the input also changes which ratio applies. One code of the channel's select field switches the channel off. Each channel output is a one-cycle strobe that marks the divided clock edge.

Software programs the bank through a simple write port, with valid, byte address and 32-bit data. It reads the bank back through a combinational read port. The select fields are packed two bits per channel, starting at a configurable bit position. A field that would sit past bit 31 moves into a second select word. Three read-only status words, one per input, hold one bit per channel. A channel's bit is set once the channel has selected that input and the newly selected divider has produced its first output edge. After a switch, software polls this bit to learn that the new path is live.

Top module: `clk_divmux_bank`

## Requirements
- R1: Select code 0, 1 or 2 connects the channel to input 0, 1 or 2. Code 3 switches the channel off: it gives no output strobes, and the channel's bit in all three status words reads 0.
- R2: With ratio field r, the selected input ticking every P system cycles gives one output strobe every (r+1)*P cycles. r = 0 passes every input tick through.
- R3: Each channel owns three independent 5-bit ratio fields, one per input. Each field sits in bits [4:0] of its own word at byte address DIV_BASE_k + 4*channel, where k is the input. Writing one word leaves the other words unchanged, and every word reads back what was written.
- R4: The select field of channel i sits at bit p = SEL_START + 2*i of select word 0. When p > 31, the field is at bit p-32 of select word 1. Only the addressed channel responds to its field.
- R5: Status word k has bit RUN_START + i set while channel i selects input k and has given at least one output strobe since that selection. The bit is set in the same cycle as the channel's first strobe.
- R6: After an enabled channel switches to a new input, the status bit for the old input clears at once. The status bit for the new input reads 0 and no new-path strobe appears until the new divider's first terminal count. That terminal count comes between r*P+1 and (r+1)*P cycles after the write.
- R7: While a channel is off, its dividers are held cleared and the channel gives no strobes.
- R8: After reset, every select field reads 3 (both select words read all ones), every ratio field reads 0, every status word reads 0, and no channel output is high.
- R9: The byte addresses are: select word 0 at 0x000, select word 1 at 0x004, status words for inputs 0, 1 and 2 at 0x010, 0x014 and 0x018, and ratio bases at 0x100, 0x200 and 0x300.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 3 | Enable strobes of the three input clocks, one bit per input |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ch_out | output | NUM_CH | One-cycle divided-clock strobe per channel |

## Verification
The assertions assume that reset is held for at least one clock edge, so that the select fields read 3 before they are first compared with their past values. They also assume that input ticks are single-cycle strobes sampled once each. The bench drives every input and the write port at the falling edge, so each tick is seen by exactly one rising edge. It uses fixed tick spacings of 1, 2 and 3 cycles, which makes every expected period a plain product. The bench changes a channel's input only through a whole-word write of the select word, so the other fields in that word always hold their shadowed values.

// File: rtl/divmux_pkg.sv
// Shared constants and types for the divider-mux clock bank.
// Assumes exactly three selectable inputs; code 3 is the off code.
package divmux_pkg;
    localparam int NUM_SRC = 3;
    typedef logic [1:0] sel_t;
    localparam sel_t SEL_OFF = 2'd3;
endpackage

// File: rtl/divmux_divider.sv
// Per-input ratio counter. It counts ticks of one input while that input is
// selected and flags the terminal count. It assumes tick is a single-cycle
// strobe. The counter is held at zero whenever its input is not selected.
module divmux_divider #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic [DIV_W-1:0] ratio,
    output logic             fire
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    // A count at or above the ratio ends the period, which covers a ratio shrunk mid-count.
    assign at_end = (cnt_q >= ratio);
    assign fire   = active & tick & at_end;

    // Count the input ticks; restart on terminal count or when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/divmux_channel.sv
// One output channel. It holds three dividers, one per input; only the
// divider of the selected input runs. It drives a registered output strobe
// and a per-input "running" flag, set on the first strobe after selection.
// It assumes sel comes straight from a register.
module divmux_channel
    import divmux_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              src_tick,
    input  sel_t                            sel,
    input  logic [NUM_SRC-1:0][DIV_W-1:0]   ratio,
    output logic [NUM_SRC-1:0]              run_vis,
    output logic                            out_pulse
);
    logic [NUM_SRC-1:0] hit;
    logic [NUM_SRC-1:0] fire;
    logic [NUM_SRC-1:0] run_q;
    logic               out_q;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        assign hit[k] = (sel == sel_t'(k));

        divmux_divider #(.DIV_W(DIV_W)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (hit[k]),
            .tick   (src_tick[k]),
            .ratio  (ratio[k]),
            .fire   (fire[k])
        );

        // Running flag: set by the first terminal count and cleared once the input is deselected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_q[k] <= 1'b0;
            end else begin
                run_q[k] <= hit[k] ? (run_q[k] | fire[k]) : 1'b0;
            end
        end
    end

    // Register the output strobe of whichever divider fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= |fire;
        end
    end

    // Gate the flags with the live select, so a stale flag is never visible after a switch.
    assign run_vis   = run_q & hit;
    assign out_pulse = out_q;
endmodule

// File: rtl/divmux_regs.sv
// Register file of the bank. It holds two select words and one ratio word
// per channel per input, decodes byte-addressed writes, and serves a
// combinational read port that includes the per-input status words. It
// assumes word-aligned addresses and SEL_START + 2*NUM_CH <= 64.
module divmux_regs
    import divmux_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DIV_W     = 5,
    parameter int ADDR_W    = 12,
    parameter int SEL_START = 28,
    parameter int RUN_START = 4,
    parameter int SEL_ADDR0 = 'h000,
    parameter int SEL_ADDR1 = 'h004,
    parameter int RUN_ADDR0 = 'h010,
    parameter int RUN_ADDR1 = 'h014,
    parameter int RUN_ADDR2 = 'h018,
    parameter int DIV_BASE0 = 'h100,
    parameter int DIV_BASE1 = 'h200,
    parameter int DIV_BASE2 = 'h300
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       wr_valid,
    input  logic [ADDR_W-1:0]                          wr_addr,
    input  logic [31:0]                                wr_data,
    input  logic [ADDR_W-1:0]                          rd_addr,
    output logic [31:0]                                rd_data,
    input  logic [NUM_CH-1:0][NUM_SRC-1:0]             ch_run,
    output logic [NUM_CH-1:0][1:0]                     ch_sel,
    output logic [NUM_CH-1:0][NUM_SRC-1:0][DIV_W-1:0]  ch_ratio
);
    localparam int DIV_BASES [NUM_SRC] = '{DIV_BASE0, DIV_BASE1, DIV_BASE2};
    localparam int RUN_ADDRS [NUM_SRC] = '{RUN_ADDR0, RUN_ADDR1, RUN_ADDR2};

    logic [31:0] sel_w0_q;
    logic [31:0] sel_w1_q;
    logic [NUM_CH-1:0][NUM_SRC-1:0][DIV_W-1:0] div_q;

    // Decode writes into the select words and the ratio words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_w0_q <= '1;
            sel_w1_q <= '1;
            div_q    <= '0;
        end else if (wr_valid) begin
            if (wr_addr == ADDR_W'(SEL_ADDR0)) sel_w0_q <= wr_data;
            if (wr_addr == ADDR_W'(SEL_ADDR1)) sel_w1_q <= wr_data;
            for (int c = 0; c < NUM_CH; c++) begin
                for (int k = 0; k < NUM_SRC; k++) begin
                    if (wr_addr == ADDR_W'(DIV_BASES[k] + 4 * c)) begin
                        div_q[c][k] <= wr_data[DIV_W-1:0];
                    end
                end
            end
        end
    end

    // Map each channel's select field, which spills into the second word past bit 31.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        localparam int POS = SEL_START + 2 * c;
        if (POS > 31) begin : g_hi
            assign ch_sel[c] = sel_w1_q[POS-32 +: 2];
        end else begin : g_lo
            assign ch_sel[c] = sel_w0_q[POS +: 2];
        end
    end

    assign ch_ratio = div_q;

    // Combinational read mux over the select, status and ratio words.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(SEL_ADDR0)) rd_data = sel_w0_q;
        if (rd_addr == ADDR_W'(SEL_ADDR1)) rd_data = sel_w1_q;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (rd_addr == ADDR_W'(RUN_ADDRS[k])) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    rd_data[RUN_START + c] = ch_run[c][k];
                end
            end
        end
        for (int c = 0; c < NUM_CH; c++) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                if (rd_addr == ADDR_W'(DIV_BASES[k] + 4 * c)) begin
                    rd_data[DIV_W-1:0] = div_q[c][k];
                end
            end
        end
    end
endmodule

// File: rtl/clk_divmux_bank.sv
// Top of the divider-mux clock bank: a register file plus NUM_CH channels.
// It assumes the three inputs arrive as single-cycle enable strobes in the
// clk domain, and that RUN_START + NUM_CH <= 32.
module clk_divmux_bank
    import divmux_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DIV_W     = 5,
    parameter int ADDR_W    = 12,
    parameter int SEL_START = 28,
    parameter int RUN_START = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           src_tick,
    input  logic                 wr_valid,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [31:0]          rd_data,
    output logic [NUM_CH-1:0]    ch_out
);
    logic [NUM_CH-1:0][1:0]                    ch_sel;
    logic [NUM_CH-1:0][NUM_SRC-1:0]            ch_run;
    logic [NUM_CH-1:0][NUM_SRC-1:0][DIV_W-1:0] ch_ratio;

    divmux_regs #(
        .NUM_CH    (NUM_CH),
        .DIV_W     (DIV_W),
        .ADDR_W    (ADDR_W),
        .SEL_START (SEL_START),
        .RUN_START (RUN_START)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .ch_run   (ch_run),
        .ch_sel   (ch_sel),
        .ch_ratio (ch_ratio)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        divmux_channel #(.DIV_W(DIV_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_tick  (src_tick),
            .sel       (ch_sel[c]),
            .ratio     (ch_ratio[c]),
            .run_vis   (ch_run[c]),
            .out_pulse (ch_out[c])
        );
    end
endmodule

// File: rtl/divmux_bank_chk.sv
// Property checker for the clock bank, attached to every instance by bind.
module divmux_bank_chk #(
    parameter int NUM_CH = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [2:0]             src_tick,
    input logic [NUM_CH-1:0]      ch_out,
    input logic [NUM_CH-1:0][1:0] ch_sel,
    input logic [NUM_CH-1:0][2:0] ch_run
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R7
        off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_sel[i] == 2'd3 && $past(ch_sel[i]) == 2'd3) |-> !ch_out[i]);

        // R5
        run_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_out[i] && ch_sel[i] != 2'd3 && $stable(ch_sel[i])) |-> ch_run[i][ch_sel[i]]);

        // R6
        run_rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(|ch_run[i]) |-> ch_out[i]);

        // R1
        one_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(ch_run[i]));

        // R2
        pulse_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_out[i] |-> $past(|src_tick));
    end
endmodule

bind clk_divmux_bank divmux_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .ch_out   (ch_out),
    .ch_sel   (ch_sel),
    .ch_run   (ch_run)
);

// File: tb/sim_clk_divmux_bank.sv
`timescale 1ns/1ps
module sim_clk_divmux_bank;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 12;
    localparam int SEL_START = 28;
    localparam int RUN_START = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        src_tick = '0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic [NUM_CH-1:0] ch_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int cyc     = 0;
    logic [63:0] sel_sh = '1;

    clk_divmux_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
                      .SEL_START(SEL_START), .RUN_START(RUN_START)) u0 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ch_out(ch_out)
    );

    always #4 clk = ~clk;

    // Input strobes: input 0 every cycle, input 1 every 2nd, input 2 every 3rd.
    initial forever begin
        @(negedge clk);
        cyc++;
        src_tick <= {(cyc % 3 == 0), (cyc % 2 == 0), 1'b1};
    end

    function automatic int spacing(input int k);
        return k + 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = ADDR_W'(addr);
        wr_data  = data;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        rd_addr = ADDR_W'(addr);
        #1;
        data = rd_data;
    endtask

    task automatic set_sel(input int ch, input int v);
        int pos = SEL_START + 2 * ch;
        sel_sh[pos +: 2] = 2'(v);
        wr((pos / 32) * 4, sel_sh[(pos / 32) * 32 +: 32]);
    endtask

    // Count cycles until the channel strobes; -1 on timeout.
    task automatic wait_pulse(input int ch, input int maxc, output int n);
        n = 0;
        while (n < maxc) begin
            @(negedge clk);
            n++;
            if (ch_out[ch]) return;
        end
        n = -1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n, prev, lo, hi, per;
        int ratios [8] = '{0, 1, 2, 3, 7, 16, 30, 31};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 and R9: reset contents at their addresses
        rd('h000, d); chk(d == 32'hFFFF_FFFF, "R8 sel word0 reset", d, 32'hFFFF_FFFF);
        rd('h004, d); chk(d == 32'hFFFF_FFFF, "R8 sel word1 reset", d, 32'hFFFF_FFFF);
        for (int k = 0; k < 3; k++) begin
            rd('h010 + 4 * k, d); chk(d == 0, "R8 status reset", d, 0);
        end
        for (int c = 0; c < NUM_CH; c++)
            for (int k = 0; k < 3; k++) begin
                rd('h100 * (k + 1) + 4 * c, d); chk(d == 0, "R8 ratio reset", d, 0);
            end
        chk(ch_out == 0, "R8 outputs low", ch_out, 0);

        // R3 and R9: independent ratio words read back
        for (int c = 0; c < NUM_CH; c++)
            for (int k = 0; k < 3; k++) wr('h100 * (k + 1) + 4 * c, 32'(c * 3 + k + 1));
        for (int c = 0; c < NUM_CH; c++)
            for (int k = 0; k < 3; k++) begin
                rd('h100 * (k + 1) + 4 * c, d);
                chk(d == 32'(c * 3 + k + 1), "R3 ratio word readback", d, c * 3 + k + 1);
            end

        for (int ch = 0; ch < NUM_CH; ch++) begin
            prev = 3;
            foreach (ratios[ri]) begin
                for (int src = 0; src < 3; src++) begin
                    per = (ratios[ri] + 1) * spacing(src);
                    wr('h100 * (src + 1) + 4 * ch, 32'(ratios[ri]));
                    set_sel(ch, src);
                    // R6: new path not yet running, old path cleared at once
                    rd('h010 + 4 * src, d);
                    chk(d[RUN_START + ch] == 1'b0, "R6 new input bit clear after switch", d[RUN_START + ch], 0);
                    if (prev != 3) begin
                        rd('h010 + 4 * prev, d);
                        chk(d[RUN_START + ch] == 1'b0, "R6 old input bit cleared", d[RUN_START + ch], 0);
                    end
                    // R6: first strobe lands within the new divider's first period
                    wait_pulse(ch, 4 * per + 10, n);
                    lo = ratios[ri] * spacing(src) + 1;
                    hi = per;
                    chk(n >= lo && n <= hi, "R6 first pulse latency", n, hi);
                    // R5: running bit rises with the first strobe
                    rd('h010 + 4 * src, d);
                    chk(d[RUN_START + ch] == 1'b1, "R5 running bit with first pulse", d[RUN_START + ch], 1);
                    // R4: only this channel responds
                    chk((ch_out & ~(NUM_CH'(1) << ch)) == 0, "R4 other channels silent", ch_out, NUM_CH'(1) << ch);
                    // R2: steady period
                    wait_pulse(ch, 4 * per + 10, n);
                    chk(n == per, "R2 output period", n, per);
                    prev = src;
                end
            end
            // R1 and R7: switching off
            set_sel(ch, 3);
            for (int k = 0; k < 3; k++) begin
                rd('h010 + 4 * k, d);
                chk(d[RUN_START + ch] == 1'b0, "R1 status clear when off", d[RUN_START + ch], 0);
            end
            n = 0;
            for (int i = 0; i < 120; i++) begin
                @(negedge clk);
                if (i > 0 && ch_out[ch]) n++;
            end
            chk(n == 0, "R7 no pulses while off", n, 0);
        end

        // R4: select words hold the packed fields written
        rd('h000, d); chk(d == sel_sh[31:0], "R4 sel word0 layout", d, sel_sh[31:0]);
        rd('h004, d); chk(d == sel_sh[63:32], "R4 sel word1 layout", d, sel_sh[63:32]);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule